// File: doc/BRIEF.md
# Masked Stream Bit Packer

The block takes a stream of narrow input words, each paired with a bit mask, and gathers the masked bits into full-width output words. The set bits of each mask form one contiguous run. Those bits are shifted down to bit 0 and placed directly above the bits already held, so packing starts at the LSB. Whenever at least one output word of bits is held, the block offers it on the output handshake with an all-ones mask. Bits beyond that word stay behind as the low bits of the next word.

The input width and the output width are independent parameters and need not divide evenly. The accumulator is as wide as both widths together, so one more input always fits while a full word waits. For simplicity, input ready follows output ready: it drops whenever the consumer stalls.

A flush request drains the accumulator. It emits any full words that remain, then a final word whose mask covers only the bits still held. It clears the state and raises a one-cycle completion flag. If nothing is stored, the flag comes without any output beat. The block takes no input while a flush is in progress.

Top module: `bit_packer`

## Requirements
- R1: Only the input bits under the (contiguous) mask are taken. They are right-aligned and appended directly above the bits already held, so the first accepted bit becomes output bit 0.
- R2: Once at least OUT_W bits are held, valid_o is high and data_o carries the lowest OUT_W held bits with mask_o all ones. Bits left over become the low bits of the next word. With IN_W=4 and OUT_W=6, full-mask inputs 0h, 1h, 2h, 3h, 4h, 5h give outputs 10h, 08h, 03h, 15h.
- R3: ready_o is low in every cycle in which ready_i is low.
- R4: While valid_o is high and ready_i is low, valid_o, data_o and mask_o hold their values.
- R5: A one-cycle flush_i pulse drains all held bits. Full words go first with full masks. A last partial word has mask_o set in its low n bits, where n is the number of bits left (for example 0Fh for four bits). Afterwards the state is empty.
- R6: flush_done_o pulses high for exactly one cycle once the drain is complete. If the accumulator is empty when the flush starts, the pulse comes with no output beat.
- R7: From the cycle after flush_i is seen until flush_done_o, ready_o stays low.
- R8: An accepted input whose mask is all zeros adds no bits.
- R9: After reset, valid_o and flush_done_o are low and ready_o equals ready_i.
- R10: Whenever valid_o is high, mask_o is nonzero and consists only of contiguous ones starting at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word present |
| data_i | input | IN_W | Input data |
| mask_i | input | IN_W | Contiguous mask of valid input bits |
| ready_o | output | 1 | Block accepts an input word |
| valid_o | output | 1 | Output word present |
| data_o | output | OUT_W | Packed output data |
| mask_o | output | OUT_W | Valid bits of the output word |
| ready_i | input | 1 | Consumer accepts the output word |
| flush_i | input | 1 | Request to drain held bits |
| flush_done_o | output | 1 | One-cycle flag: drain finished |

## Verification
Full-mask inputs at the default 4-to-6 ratio check the carry of leftover bits across word boundaries, where an off-by-one shift or a lost remainder shows up at once. Masks with runs that start above bit 0 and have various lengths show whether extraction right-aligns the run, and not merely whether it keeps the masked bits. All-zero masks and a flush on an empty store separate "accepted but adds nothing" from "emits a spurious beat". Stalling the consumer with a word pending, and during a flush, shows that the output holds and that input is gated.

// File: rtl/bit_packer_pkg.sv
package bit_packer_pkg;
  typedef enum logic [1:0] {
    BEAT_NONE = 2'd0,
    BEAT_FULL = 2'd1,
    BEAT_PART = 2'd2
  } beat_e;
endpackage

// File: rtl/bit_packer_align.sv
module bit_packer_align #(
  parameter int IN_W  = 4,
  parameter int LEN_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  data_i,
  input  logic [IN_W-1:0]  mask_i,
  output logic [IN_W-1:0]  bits_o,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] lsb;

  always_comb begin
    lsb   = '0;
    len_o = '0;
    for (int i = IN_W - 1; i >= 0; i--) begin
      if (mask_i[i]) lsb = LEN_W'(i);
    end
    for (int i = 0; i < IN_W; i++) begin
      len_o = len_o + LEN_W'(mask_i[i]);
    end
    bits_o = (data_i & mask_i) >> lsb;
  end
endmodule

// File: rtl/bit_packer_store.sv
module bit_packer_store
  import bit_packer_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int OUT_W = 6,
  parameter int ACC_W = IN_W + OUT_W,
  parameter int CNT_W = $clog2(ACC_W + 1),
  parameter int LEN_W = $clog2(IN_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  beat_e            pop_i,
  input  logic             push_i,
  input  logic [IN_W-1:0]  bits_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);
  localparam logic [CNT_W-1:0] ACC_CNT = CNT_W'(ACC_W);

  logic [ACC_W-1:0] acc_q, acc_d, base_acc;
  logic [CNT_W-1:0] cnt_q, cnt_d, base_cnt;

  always_comb begin
    unique case (pop_i)
      BEAT_FULL: begin base_acc = acc_q >> OUT_W; base_cnt = cnt_q - OUT_CNT; end
      BEAT_PART: begin base_acc = '0;             base_cnt = '0;              end
      default:   begin base_acc = acc_q;          base_cnt = cnt_q;           end
    endcase
    acc_d = base_acc;
    cnt_d = base_cnt;
    if (push_i) begin
      acc_d = base_acc | (ACC_W'(bits_i) << base_cnt);
      cnt_d = base_cnt + CNT_W'(len_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

  assign acc_o = acc_q;
  assign cnt_o = cnt_q;

  // capacity never exceeded
  p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= ACC_CNT);

  // bits above the held count are always zero, so a partial beat is clean
  p_upper_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q >> cnt_q) == '0);
endmodule

// File: rtl/bit_packer.sv
module bit_packer
  import bit_packer_pkg::*;
#(
  parameter int IN_W  = 4,
  parameter int OUT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [IN_W-1:0]  data_i,
  input  logic [IN_W-1:0]  mask_i,
  output logic             ready_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic [OUT_W-1:0] mask_o,
  input  logic             ready_i,
  input  logic             flush_i,
  output logic             flush_done_o
);
  localparam int ACC_W = IN_W + OUT_W;
  localparam int CNT_W = $clog2(ACC_W + 1);
  localparam int LEN_W = $clog2(IN_W + 1);
  localparam logic [CNT_W-1:0] OUT_CNT = CNT_W'(OUT_W);

  logic [IN_W-1:0]  bits;
  logic [LEN_W-1:0] len;
  logic [ACC_W-1:0] acc_q;
  logic [CNT_W-1:0] cnt_q, cnt_eff;
  logic             full_w, part_w, push, flush_q;
  beat_e            pop_kind;

  bit_packer_align #(.IN_W(IN_W), .LEN_W(LEN_W)) u_align (
    .data_i (data_i),
    .mask_i (mask_i),
    .bits_o (bits),
    .len_o  (len)
  );

  bit_packer_store #(
    .IN_W(IN_W), .OUT_W(OUT_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .LEN_W(LEN_W)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pop_i  (pop_kind),
    .push_i (push),
    .bits_i (bits),
    .len_i  (len),
    .acc_o  (acc_q),
    .cnt_o  (cnt_q)
  );

  assign full_w  = cnt_q >= OUT_CNT;
  assign part_w  = flush_q && !full_w && (cnt_q != '0);
  assign valid_o = full_w || part_w;
  assign data_o  = acc_q[OUT_W-1:0];

  always_comb begin
    pop_kind = BEAT_NONE;
    if (valid_o && ready_i) pop_kind = full_w ? BEAT_FULL : BEAT_PART;
  end

  // room is judged after a pending full word leaves; stall whenever output stalls
  assign cnt_eff = full_w ? cnt_q - OUT_CNT : cnt_q;
  assign ready_o = ready_i && !flush_q && (cnt_eff < OUT_CNT);
  assign push    = valid_i && ready_o;

  for (genvar i = 0; i < OUT_W; i++) begin : g_mask
    assign mask_o[i] = full_w || (cnt_q > CNT_W'(i));
  end

  assign flush_done_o = flush_q && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flush_q <= 1'b0;
    else if (flush_q) flush_q <= (cnt_q != '0);
    else              flush_q <= flush_i;
  end

  p_ready_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> !ready_o);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o) && $stable(mask_o)));

  p_full_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !flush_q) |-> (mask_o == '1));

  p_done_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |-> !valid_o);

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_done_o |=> !flush_done_o);

  p_flush_block_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_q |-> !ready_o);

  p_zero_push_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o && (mask_i == '0) && !(valid_o && ready_i))
      |=> $stable(cnt_q));

  p_mask_form_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((mask_o != '0) && (((mask_o + 1'b1) & mask_o) == '0)));
endmodule

// File: tb/bit_packer_tb.sv
module bit_packer_tb;
  localparam int IN_W  = 4;
  localparam int OUT_W = 6;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             valid_i = 1'b0;
  logic [IN_W-1:0]  data_i = '0;
  logic [IN_W-1:0]  mask_i = '0;
  logic             ready_o;
  logic             valid_o;
  logic [OUT_W-1:0] data_o;
  logic [OUT_W-1:0] mask_o;
  logic             ready_i = 1'b1;
  logic             flush_i = 1'b0;
  logic             flush_done_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [OUT_W-1:0] got_d [64];
  logic [OUT_W-1:0] got_m [64];
  int               n_got = 0;
  logic [OUT_W-1:0] exp_d [64];
  logic [OUT_W-1:0] exp_m [64];
  int               n_exp = 0;
  logic [63:0]      mbits = '0;
  int               mn = 0;
  int               n_done = 0;

  always #4 clk = ~clk;

  bit_packer #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .data_i(data_i),
    .mask_i(mask_i), .ready_o(ready_o), .valid_o(valid_o), .data_o(data_o),
    .mask_o(mask_o), .ready_i(ready_i), .flush_i(flush_i),
    .flush_done_o(flush_done_o)
  );

  // mid-cycle monitor
  always @(negedge clk) begin
    if (rst_ni && valid_o && ready_i && n_got < 64) begin
      got_d[n_got] = data_o;
      got_m[n_got] = mask_o;
      n_got++;
    end
    if (rst_ni && flush_done_o) n_done++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  task automatic model_push(input logic [IN_W-1:0] d, input logic [IN_W-1:0] m);
    for (int i = 0; i < IN_W; i++) begin
      if (m[i]) begin mbits[mn] = d[i]; mn++; end
    end
    while (mn >= OUT_W) begin
      exp_d[n_exp] = mbits[OUT_W-1:0];
      exp_m[n_exp] = '1;
      n_exp++;
      mbits = mbits >> OUT_W;
      mn -= OUT_W;
    end
  endtask

  task automatic model_flush();
    if (mn > 0) begin
      exp_d[n_exp] = mbits[OUT_W-1:0];
      exp_m[n_exp] = OUT_W'((1 << mn) - 1);
      n_exp++;
    end
    mbits = '0;
    mn = 0;
  endtask

  task automatic compare(input string req);
    chk({req, " beat count"}, n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      chk({req, " data"}, got_d[i], exp_d[i]);
      chk({req, " mask"}, got_m[i], exp_m[i]);
    end
    n_got = 0;
    n_exp = 0;
  endtask

  task automatic send(input logic [IN_W-1:0] d, input logic [IN_W-1:0] m);
    @(posedge clk); #1;
    valid_i = 1'b1; data_i = d; mask_i = m;
    forever begin
      @(negedge clk);
      if (ready_o) break;
    end
    model_push(d, m);
    @(posedge clk); #1;
    valid_i = 1'b0;
  endtask

  task automatic flush_wait(input string req);
    int d0;
    int t;
    d0 = n_done;
    @(posedge clk); #1;
    flush_i = 1'b1;
    @(posedge clk); #1;
    flush_i = 1'b0;
    model_flush();
    t = 0;
    while (n_done == d0 && t < 50) begin @(negedge clk); t++; end
    chk({req, " done seen"}, n_done - d0, 1);
    @(negedge clk);
    chk({req, " done one cycle"}, flush_done_o, 1'b0);
    chk({req, " cleared"}, valid_o, 1'b0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9 valid_o", valid_o, 1'b0);
    chk("R9 flush_done_o", flush_done_o, 1'b0);
    chk("R9 ready_o", ready_o, 1'b1);
  endtask

  task automatic t_example();
    for (int i = 0; i < 7; i++) send(IN_W'(i), '1);
    chk("R2 first word", got_d[0], 32'h10);
    chk("R2 second word", got_d[1], 32'h08);
    chk("R2 third word", got_d[2], 32'h03);
    chk("R2 fourth word", got_d[3], 32'h15);
    flush_wait("R6 example");
    chk("R5 remnant data", got_d[4], 32'h06);
    chk("R5 remnant mask", got_m[4], 32'h0F);
    compare("R2 R5 example");
  endtask

  task automatic t_masks();
    send(4'b1010, 4'b0110);
    send(4'b1111, 4'b1000);
    send(4'b0101, 4'b0111);
    send(4'b1100, 4'b1100);
    send(4'b0110, 4'b0010);
    send(4'b1011, 4'b1111);
    send(4'b0100, 4'b1110);
    flush_wait("R6 masks");
    compare("R1 masked runs");
  endtask

  task automatic t_zero();
    send(4'hF, 4'h0);
    send(4'hA, 4'h0);
    chk("R8 no beat", n_got, 0);
    flush_wait("R6 empty");
    chk("R6 empty no beat", n_got, 0);
    send(4'h3, 4'h0);
    send(4'h5, 4'hF);
    send(4'hF, 4'h0);
    send(4'h9, 4'h3);
    flush_wait("R8 mixed");
    compare("R8 zero mask");
  endtask

  task automatic t_stall();
    logic [OUT_W-1:0] d0, m0;
    send(4'h6, '1);
    @(posedge clk); #1;
    valid_i = 1'b1; data_i = 4'h9; mask_i = '1;
    @(negedge clk);
    model_push(4'h9, '1);
    @(posedge clk); #1;
    valid_i = 1'b0;
    ready_i = 1'b0;
    @(negedge clk);
    chk("R3 ready_o low", ready_o, 1'b0);
    chk("R4 pending", valid_o, 1'b1);
    d0 = data_o; m0 = mask_o;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 valid held", valid_o, 1'b1);
      chk("R4 data held", data_o, d0);
      chk("R4 mask held", mask_o, m0);
    end
    @(posedge clk); #1;
    ready_i = 1'b1;
    flush_wait("R6 stall");
    compare("R4 stall");
  endtask

  task automatic t_flush_block();
    send(4'h5, 4'h7);
    @(posedge clk); #1;
    ready_i = 1'b0;
    flush_i = 1'b1;
    @(posedge clk); #1;
    flush_i = 1'b0;
    model_flush();
    @(negedge clk);
    chk("R5 remnant pending", valid_o, 1'b1);
    chk("R5 remnant mask", mask_o, 32'h07);
    @(posedge clk); #1;
    ready_i = 1'b1;
    valid_i = 1'b1; data_i = 4'hF; mask_i = '1;
    @(negedge clk);
    chk("R7 input blocked", ready_o, 1'b0);
    @(negedge clk);
    chk("R7 blocked at done", ready_o, 1'b0);
    chk("R6 done", flush_done_o, 1'b1);
    @(posedge clk); #1;
    valid_i = 1'b0;
    compare("R5 flush remnant");
    @(negedge clk);
    chk("R7 ready after done", ready_o, 1'b1);
  endtask

  task automatic t_backfill();
    for (int i = 0; i < 12; i++) send(IN_W'(i * 5 + 3), (i % 3 == 0) ? 4'b0011 : 4'b1111);
    flush_wait("R6 long");
    compare("R10 long stream");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_example();
    t_masks();
    t_zero();
    t_stall();
    t_flush_block();
    t_backfill();
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule